// File: doc/BRIEF.md
# Lowest-Priority Interrupt Target Router

This block sends every interrupt request to a single CPU out of `NCPU`. Each interrupt line owns a routing entry made of a CPU mask and a mode flag. In fixed mode the entry's CPU is the lowest set bit of its mask. In redirectable mode the same bit names a default CPU, and the interrupt goes to the CPU with the smallest priority hint. The search for that CPU starts at the default CPU and moves upward, wrapping past the top CPU.

Software programs entries and per-CPU hints through one write port. A combinational read port returns any entry. Interrupt requests are one-cycle pulses, and any number of them may arrive in the same cycle. The block keeps unserviced requests pending and delivers one per cycle, lowest interrupt number first. A delivery is a one-cycle strobe on the chosen CPU's line, together with the interrupt number on the vector bus.

Top module: `lp_irq_router`

## Requirements
- R1: At most one bit of `dlv_stb` is high in any cycle, so each delivery reaches exactly one CPU.
- R2: A fixed entry (mode 0) delivers to the CPU given by the lowest set bit of its mask, whatever higher bits are set.
- R3: `rd_data` for entry `rd_addr` returns the mode in bit `NCPU` (1 = redirectable) and, in bits `NCPU-1:0`, the written mask with only its lowest set bit kept.
- R4: An entry write (`wr_hint`=0) whose mask bits `wr_data[NCPU-1:0]` are all zero is ignored, and both the mask and the mode of that entry stay as they were.
- R5: A redirectable entry (mode 1) delivers to the CPU whose hint is smallest. Hints are encoded as 2'b00 minimal, 2'b01 normal and 2'b10 maximal.
- R6: Among CPUs that tie on the smallest hint, the winner is the first one met when searching upward from the entry's default CPU, wrapping from `NCPU-1` to 0.
- R7: A CPU at the maximal hint is never chosen while any CPU is below maximal. When every CPU is maximal, the default CPU is chosen.
- R8: A hint write (`wr_hint`=1) of value 2'b11 in `wr_data[1:0]` is ignored, and the hint keeps its previous level.
- R9: With `REDIRECT`=1, reset leaves every entry redirectable with mask 1 (CPU 0) and every hint minimal.
- R10: With `REDIRECT`=0, reset leaves entry i in fixed mode targeting CPU i mod `NCPU`.
- R11: A request pulse in a cycle gives a strobe in the next cycle. Requests that arrive together, or that are still pending, are delivered one per cycle in ascending interrupt number.
- R12: A delivery decided in the same cycle as a write to an entry or hint uses the values from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_hint | input | 1 | 1 = write a CPU hint, 0 = write a routing entry |
| wr_addr | input | IW | Entry number, or CPU number for a hint write |
| wr_data | input | NCPU+1 | Entry: {mode, mask}; hint: level in bits 1:0 |
| rd_addr | input | IW | Entry to read |
| rd_data | output | NCPU+1 | {mode, effective one-hot mask} |
| irq_req | input | NIRQ | One request pulse per interrupt line |
| dlv_stb | output | NCPU | Per-CPU delivery strobe |
| dlv_vec | output | VEC_W | Interrupt number of the current delivery |

## Verification
Two activities can share a cycle: a routing decision and a register write that changes the state the decision reads. The bench raises a request in the same cycle that it lowers a CPU's hint or rewrites an entry. It expects the delivery to follow the old values and the following request to follow the new ones. Separately, several request lines are pulsed together, and the bench checks that the strobes come out one per cycle in ascending interrupt order.

// File: rtl/lp_pkg.sv
package lp_pkg;
  typedef enum logic [1:0] {
    HINT_MIN  = 2'b00,
    HINT_NORM = 2'b01,
    HINT_MAX  = 2'b10
  } hint_e;
  localparam logic [1:0] HINT_BAD = 2'b11;
endpackage

// File: rtl/lp_route_table.sv
module lp_route_table #(
  parameter int NCPU = 4,
  parameter int NIRQ = 8,
  parameter bit REDIRECT = 1'b1,
  localparam int IW = $clog2(NIRQ),
  localparam int CW = $clog2(NCPU)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_hint,
  input  logic [IW-1:0]      wr_addr,
  input  logic [NCPU:0]      wr_data,
  input  logic [IW-1:0]      rd_addr,
  output logic [NCPU:0]      rd_data,
  input  logic [IW-1:0]      svc_irq,
  output logic [NCPU-1:0]    svc_mask,
  output logic               svc_mode,
  output logic [2*NCPU-1:0]  hints_flat
);
  import lp_pkg::*;

  logic [NCPU-1:0] mask_q [NIRQ];
  logic            mode_q [NIRQ];
  hint_e           hint_q [NCPU];

  function automatic logic [NCPU-1:0] keep_lowest(input logic [NCPU-1:0] m);
    return m & (~m + NCPU'(1));
  endfunction

  function automatic logic [NCPU-1:0] reset_mask(input int idx);
    if (REDIRECT) return NCPU'(1);
    return NCPU'(1) << (idx % NCPU);
  endfunction

  wire entry_wr = wr_en && !wr_hint && (wr_data[NCPU-1:0] != '0);
  wire hint_wr  = wr_en &&  wr_hint && (wr_data[1:0] != HINT_BAD);

  for (genvar i = 0; i < NIRQ; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q[i] <= reset_mask(i);
        mode_q[i] <= REDIRECT;
      end else if (entry_wr && wr_addr == IW'(i)) begin
        mask_q[i] <= keep_lowest(wr_data[NCPU-1:0]);
        mode_q[i] <= wr_data[NCPU];
      end
    end
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_hint
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hint_q[c] <= HINT_MIN;
      else if (hint_wr && wr_addr == IW'(c)) hint_q[c] <= hint_e'(wr_data[1:0]);
    end
    assign hints_flat[2*c +: 2] = hint_q[c];
  end

  assign rd_data  = {mode_q[rd_addr], mask_q[rd_addr]};
  assign svc_mask = mask_q[svc_irq];
  assign svc_mode = mode_q[svc_irq];
endmodule

// File: rtl/lp_pick.sv
module lp_pick #(
  parameter int NCPU = 4,
  localparam int CW = $clog2(NCPU)
) (
  input  logic [2*NCPU-1:0] hints_flat,
  input  logic [CW-1:0]     start,
  output logic [CW-1:0]     pick,
  output logic [1:0]        pick_hint,
  output logic              all_max
);
  import lp_pkg::*;

  always_comb begin
    logic [2:0] best;
    int idx;
    best    = 3'd4;
    pick    = start;
    all_max = 1'b1;
    for (int k = 0; k < NCPU; k++) begin
      idx = int'(start) + k;
      if (idx >= NCPU) idx = idx - NCPU;
      if ({1'b0, hints_flat[2*idx +: 2]} < best) begin
        best = {1'b0, hints_flat[2*idx +: 2]};
        pick = CW'(idx);
      end
      if (hints_flat[2*idx +: 2] != HINT_MAX) all_max = 1'b0;
    end
    pick_hint = best[1:0];
  end
endmodule

// File: rtl/lp_req_arb.sv
module lp_req_arb #(
  parameter int NIRQ = 8,
  localparam int IW = $clog2(NIRQ)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] irq_req,
  output logic            svc_fire,
  output logic [IW-1:0]   svc_irq
);
  logic [NIRQ-1:0] pend_q;
  wire  [NIRQ-1:0] live = pend_q | irq_req;

  always_comb begin
    svc_irq = '0;
    for (int i = NIRQ - 1; i >= 0; i--)
      if (live[i]) svc_irq = IW'(i);
  end
  assign svc_fire = |live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= live & ~(NIRQ'(svc_fire) << svc_irq);
  end
endmodule

// File: rtl/lp_irq_router.sv
module lp_irq_router #(
  parameter int NCPU = 4,
  parameter int NIRQ = 8,
  parameter int VEC_W = 8,
  parameter bit REDIRECT = 1'b1,
  localparam int IW = $clog2(NIRQ),
  localparam int CW = $clog2(NCPU)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_hint,
  input  logic [IW-1:0]    wr_addr,
  input  logic [NCPU:0]    wr_data,
  input  logic [IW-1:0]    rd_addr,
  output logic [NCPU:0]    rd_data,
  input  logic [NIRQ-1:0]  irq_req,
  output logic [NCPU-1:0]  dlv_stb,
  output logic [VEC_W-1:0] dlv_vec
);
  logic            svc_fire;
  logic [IW-1:0]   svc_irq;
  logic [NCPU-1:0] svc_mask;
  logic            svc_mode;
  logic [2*NCPU-1:0] hints_flat;
  logic [CW-1:0]   pick;
  logic [1:0]      pick_hint;
  logic            all_max;
  logic [CW-1:0]   dflt_cpu;
  logic [CW-1:0]   tgt_cpu;

  function automatic logic [CW-1:0] onehot_idx(input logic [NCPU-1:0] m);
    logic [CW-1:0] r;
    r = '0;
    for (int i = NCPU - 1; i >= 0; i--)
      if (m[i]) r = CW'(i);
    return r;
  endfunction

  lp_req_arb #(.NIRQ(NIRQ)) u_arb (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
    .svc_fire(svc_fire), .svc_irq(svc_irq)
  );

  lp_route_table #(.NCPU(NCPU), .NIRQ(NIRQ), .REDIRECT(REDIRECT)) u_tbl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hint(wr_hint),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .svc_irq(svc_irq), .svc_mask(svc_mask), .svc_mode(svc_mode),
    .hints_flat(hints_flat)
  );

  assign dflt_cpu = onehot_idx(svc_mask);

  lp_pick #(.NCPU(NCPU)) u_pick (
    .hints_flat(hints_flat), .start(dflt_cpu), .pick(pick),
    .pick_hint(pick_hint), .all_max(all_max)
  );

  assign tgt_cpu = svc_mode ? pick : dflt_cpu;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dlv_stb <= '0;
      dlv_vec <= '0;
    end else begin
      dlv_stb <= svc_fire ? (NCPU'(1) << tgt_cpu) : '0;
      if (svc_fire) dlv_vec <= VEC_W'(svc_irq);
    end
  end
endmodule

// File: rtl/lp_irq_router_chk.sv
module lp_irq_router_chk #(
  parameter int NCPU = 4,
  parameter int NIRQ = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NIRQ-1:0] irq_req,
  input logic [NCPU-1:0] dlv_stb,
  input logic [NCPU:0]   rd_data,
  input logic            svc_fire,
  input logic            svc_mode,
  input logic [NCPU-1:0] svc_mask,
  input logic [1:0]      pick_hint,
  input logic            all_max
);
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dlv_stb)); // R1
  AST_FIXED_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    svc_fire && !svc_mode |=> dlv_stb == $past(svc_mask)); // R2
  AST_READ_ONE_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rd_data[NCPU-1:0]) == 1); // R3
  AST_SKIP_MAXIMAL: assert property (@(posedge clk) disable iff (!rst_n)
    svc_fire && svc_mode && !all_max |-> pick_hint != 2'b10); // R7
  AST_REQ_DELIVERED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req != '0 |=> dlv_stb != '0); // R11
endmodule

bind lp_irq_router lp_irq_router_chk #(.NCPU(NCPU), .NIRQ(NIRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .dlv_stb(dlv_stb),
  .rd_data(rd_data), .svc_fire(svc_fire), .svc_mode(svc_mode),
  .svc_mask(svc_mask), .pick_hint(pick_hint), .all_max(all_max)
);

// File: tb/sim_lp_irq_router.sv
module sim_lp_irq_router;
  localparam int NCPU = 4;
  localparam int NIRQ = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_hint = 1'b0;
  logic [IW-1:0] wr_addr = '0, rd_addr = '0, rd_addr1 = '0;
  logic [NCPU:0] wr_data = '0, rd_data, rd_data1;
  logic [NIRQ-1:0] irq_req = '0;
  logic [NCPU-1:0] dlv_stb, dlv_stb1;
  logic [7:0] dlv_vec, dlv_vec1;
  int checks = 0, errors = 0;
  int hm [NCPU];

  always #10 clk = ~clk;

  lp_irq_router #(.NCPU(NCPU), .NIRQ(NIRQ), .VEC_W(8), .REDIRECT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hint(wr_hint), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_req(irq_req),
    .dlv_stb(dlv_stb), .dlv_vec(dlv_vec));

  lp_irq_router #(.NCPU(NCPU), .NIRQ(NIRQ), .VEC_W(8), .REDIRECT(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .wr_en(1'b0), .wr_hint(1'b0), .wr_addr('0),
    .wr_data('0), .rd_addr(rd_addr1), .rd_data(rd_data1), .irq_req('0),
    .dlv_stb(dlv_stb1), .dlv_vec(dlv_vec1));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // lowest-hint CPU searched from d upward with wrap
  function automatic int model_pick(input int d);
    int lo = 9;
    for (int c = 0; c < NCPU; c++) if (hm[c] < lo) lo = hm[c];
    for (int k = 0; k < NCPU; k++) if (hm[(d + k) % NCPU] == lo) return (d + k) % NCPU;
    return d;
  endfunction

  task automatic wr_entry(input int irq, input bit mode, input int mask);
    @(negedge clk);
    wr_en = 1; wr_hint = 0; wr_addr = IW'(irq); wr_data = {mode, NCPU'(mask)};
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wr_hnt(input int cpu, input int lvl);
    @(negedge clk);
    wr_en = 1; wr_hint = 1; wr_addr = IW'(cpu); wr_data = (NCPU+1)'(lvl);
    @(negedge clk);
    wr_en = 0;
    if (lvl != 3) hm[cpu] = lvl;
  endtask

  task automatic fire(input string req, input int irq, input int exp_cpu);
    @(negedge clk);
    irq_req = NIRQ'(1) << irq;
    @(negedge clk);
    irq_req = '0;
    check(req, int'(dlv_stb), 1 << exp_cpu);
    check(req, int'(dlv_vec), irq);
  endtask

  task automatic t_reset();
    for (int i = 0; i < NIRQ; i++) begin
      rd_addr = IW'(i); rd_addr1 = IW'(i); #1;
      check("R9", int'(rd_data), 5'h11);
      check("R10", int'(rd_data1), 1 << (i % NCPU));
    end
    check("R1", int'(dlv_stb), 0);
    fire("R9", 0, 0);
  endtask

  task automatic t_fixed();
    wr_entry(4, 1'b0, 4'b1100);
    rd_addr = 4; #1;
    check("R3", int'(rd_data), 5'b00100);
    fire("R2", 4, 2);
    hm[2] = hm[2];
    wr_entry(4, 1'b1, 4'b0000);
    rd_addr = 4; #1;
    check("R4", int'(rd_data), 5'b00100);
    fire("R4", 4, 2);
  endtask

  task automatic t_redirect();
    wr_hnt(0, 1);
    fire("R5", 1, model_pick(0));
    wr_entry(2, 1'b1, 4'b0100);
    fire("R6", 2, model_pick(2));
    wr_hnt(0, 0); wr_hnt(1, 1); wr_hnt(2, 1); wr_hnt(3, 1);
    fire("R6", 2, model_pick(2));
    wr_hnt(0, 3);
    wr_entry(5, 1'b1, 4'b0010);
    fire("R8", 5, model_pick(1));
    wr_hnt(0, 2); wr_hnt(3, 2);
    fire("R7", 2, model_pick(2));
    wr_hnt(1, 2); wr_hnt(2, 2);
    fire("R7", 5, 1);
  endtask

  task automatic t_same_cycle();
    wr_hnt(0, 0); wr_hnt(1, 0); wr_hnt(2, 0); wr_hnt(3, 0);
    wr_entry(3, 1'b1, 4'b0001);
    @(negedge clk);
    wr_en = 1; wr_hint = 1; wr_addr = 0; wr_data = 5'd1; irq_req = 8'h08;
    @(negedge clk);
    wr_en = 0; irq_req = '0; hm[0] = 1;
    check("R12", int'(dlv_stb), 1);
    fire("R12", 3, model_pick(0));
  endtask

  task automatic t_order();
    @(negedge clk);
    irq_req = 8'b0010_0100;
    @(negedge clk);
    irq_req = 8'b0000_0001;
    check("R11", int'(dlv_vec), 2);
    check("R11", int'($countones(dlv_stb)), 1);
    @(negedge clk);
    irq_req = '0;
    check("R11", int'(dlv_vec), 0);
    @(negedge clk);
    check("R11", int'(dlv_vec), 5);
    @(negedge clk);
    check("R11", int'(dlv_stb), 0);
  endtask

  initial begin
    for (int c = 0; c < NCPU; c++) hm[c] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fixed();
    t_redirect();
    t_same_cycle();
    t_order();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule